// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the device-side control logic of a small byte-wide NOR-style flash. A host drives a synchronous bus made of a write strobe, a read strobe, an address and a data byte. Write cycles are matched against multi-write unlock sequences. A complete sequence starts a byte program, a sector erase or a chip erase. It can also enter or leave an identification mode, or set a one-way lock on the boot sector. The storage is a parameterized array of byte registers split into equal sectors, and sector 0 is the boot sector.

Program and erase run for a fixed number of clock cycles that are set by parameters. During that time `busy` is high. Reads then return a status byte instead of array contents. The host can poll the status in two ways: it can watch bit 7, which inverts the pending data bit, or it can watch bit 6, which changes on every read. The array is changed only when the timer ends, so a reset during an operation cancels it and leaves the stored bytes as they were.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: Command writes are matched on address bits [14:0] only. The first key is 0xAA written to 0x5555 and the second key is 0x55 written to 0x2AAA. Bits above bit 14 are ignored.
- R2: The two keys followed by 0xA0 to 0x5555 arm a program. The next write gives the target address and data. `busy` then stays high for exactly PROG_CYC cycles, and afterwards a read of the target returns the stored result.
- R3: A program stores the old byte ANDed with the new data, so a program can only clear bits.
- R4: The erase prefix is the two keys, 0x80 to 0x5555, and the two keys again. The prefix followed by 0x10 to 0x5555 holds `busy` for exactly ERASE_CYC cycles and then sets every byte to 0xFF. If the lock is set, bytes in the boot sector keep their values.
- R5: The erase prefix followed by 0x30 erases only the sector named by address bits [MEM_AW-1:MEM_AW-SECT_W]. If that sector is the boot sector (sector 0), `busy` stays low and nothing changes.
- R6: The two keys followed by 0x90 to 0x5555 enter identification mode. In this mode, array offset 0 reads 0x1F, offset 1 reads 0x07 and offset 2 reads the lock flag in bit 0. The mode ends either on a single 0xF0 written to any address from the idle state or on the two keys followed by 0xF0 to 0x5555.
- R7: The erase prefix followed by 0x40 to 0x5555 sets the lock flag without starting a timed operation. While the flag is set, a program aimed at the boot sector does not start and changes nothing.
- R8: A read during a timed operation returns a status byte. Bit 7 is the inverse of the pending data bit 7 when the read address equals the program target, and 0 otherwise. Bit 6 is 1 on the first read of the operation and then inverts on each further read. Bits [5:0] are 0.
- R9: Writes that arrive while `busy` is high have no effect, either on the array or on the sequence decoder.
- R10: A write that does not match the next expected step of a sequence returns the decoder to idle without side effects.
- R11: While `rst_n` is low, `busy` and `rdata` are 0. A reset during an operation cancels it and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe; `rdata` updates on the same edge |
| addr | input | ADDR_W | Byte address (command bits [14:0], array bits [MEM_AW-1:0]) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data: array byte, identification byte or status |
| busy | output | 1 | High while a program or erase timer runs |

## Verification
The hardest situations to reach from the ports are the ones inside an operation's time window. Examples are status reads that must see bit 6 alternate and bit 7 invert, a complete unlock sequence sent while a chip erase runs, and a reset that lands partway through a program. The bench reaches them by sending the final command write and then, counted from that write, issuing reads, writes or the reset within the PROG_CYC or ERASE_CYC window. It checks the array through ordinary reads after `busy` falls. The lock, which cannot be cleared by command, is reached late in a table of vectors so that the earlier vectors can still exercise an unlocked boot sector.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_PARM,
    ST_ERA1,
    ST_ERA2,
    ST_ERA3,
    ST_PBUSY,
    ST_EBUSY
  } seq_st_e;

  localparam logic [14:0] CMD_ADDR_A = 15'h5555;
  localparam logic [14:0] CMD_ADDR_B = 15'h2AAA;

  localparam logic [7:0] KEY_A    = 8'hAA;
  localparam logic [7:0] KEY_B    = 8'h55;
  localparam logic [7:0] OP_PROG  = 8'hA0;
  localparam logic [7:0] OP_ERASE = 8'h80;
  localparam logic [7:0] OP_IDIN  = 8'h90;
  localparam logic [7:0] OP_IDOUT = 8'hF0;
  localparam logic [7:0] OP_CHIP  = 8'h10;
  localparam logic [7:0] OP_SECT  = 8'h30;
  localparam logic [7:0] OP_LOCK  = 8'h40;

  localparam logic [7:0] ID_MFR   = 8'h1F;
  localparam logic [7:0] ID_DEV   = 8'h07;

endpackage

// File: rtl/nor_cmd_rst_sync.sv
module nor_cmd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int MEM_AW    = 8,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [14:0]              cmd_addr,
  input  logic [7:0]               wdata,
  output logic                     busy,
  output logic                     prog_busy,
  output logic                     id_mode,
  output logic                     lock,
  output logic [MEM_AW-1:0]        pend_addr,
  output logic [7:0]               pend_data,
  output logic                     commit_prog,
  output logic                     commit_erase,
  output logic [(1<<SECT_W)-1:0]   erase_mask
);

  localparam int NSECT   = 1 << SECT_W;
  localparam int CNT_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  seq_st_e            st_q, st_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [NSECT-1:0]   mask_d;
  logic               mask_we;
  logic               id_d, lock_d;
  logic               pend_we;

  logic               hit_a, hit_b;
  logic [SECT_W-1:0]  wr_sect;
  logic               in_boot;

  assign hit_a   = (cmd_addr == CMD_ADDR_A);
  assign hit_b   = (cmd_addr == CMD_ADDR_B);
  assign wr_sect = cmd_addr[MEM_AW-1 -: SECT_W];
  assign in_boot = (wr_sect == '0);
  assign pend_we = wr_en && (st_q == ST_PARM);

  // next-state logic
  always_comb begin
    st_d         = st_q;
    cnt_d        = cnt_q;
    mask_d       = erase_mask;
    mask_we      = 1'b0;
    id_d         = id_mode;
    lock_d       = lock;
    commit_prog  = 1'b0;
    commit_erase = 1'b0;
    case (st_q)
      ST_PBUSY, ST_EBUSY: begin
        // writes are not looked at while the timer runs
        if (cnt_q == '0) begin
          commit_prog  = (st_q == ST_PBUSY);
          commit_erase = (st_q == ST_EBUSY);
          st_d         = ST_IDLE;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: begin
        if (wr_en) begin
          st_d = ST_IDLE;
          case (st_q)
            ST_IDLE: begin
              if (hit_a && wdata == KEY_A) st_d = ST_KEY1;
              else if (wdata == OP_IDOUT)  id_d = 1'b0;
            end
            ST_KEY1: begin
              if (hit_b && wdata == KEY_B) st_d = ST_KEY2;
            end
            ST_KEY2: begin
              if (hit_a) begin
                case (wdata)
                  OP_PROG:  st_d = ST_PARM;
                  OP_ERASE: st_d = ST_ERA1;
                  OP_IDIN:  id_d = 1'b1;
                  OP_IDOUT: id_d = 1'b0;
                  default:  ;
                endcase
              end
            end
            ST_PARM: begin
              if (!(lock && in_boot)) begin
                st_d  = ST_PBUSY;
                cnt_d = CW'(PROG_CYC - 1);
              end
            end
            ST_ERA1: begin
              if (hit_a && wdata == KEY_A) st_d = ST_ERA2;
            end
            ST_ERA2: begin
              if (hit_b && wdata == KEY_B) st_d = ST_ERA3;
            end
            ST_ERA3: begin
              if (hit_a && wdata == OP_CHIP) begin
                mask_we = 1'b1;
                mask_d  = lock ? ~NSECT'(1) : '1;
                st_d    = ST_EBUSY;
                cnt_d   = CW'(ERASE_CYC - 1);
              end else if (wdata == OP_SECT && !in_boot) begin
                mask_we = 1'b1;
                mask_d  = NSECT'(1) << wr_sect;
                st_d    = ST_EBUSY;
                cnt_d   = CW'(ERASE_CYC - 1);
              end else if (hit_a && wdata == OP_LOCK) begin
                lock_d = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      id_mode <= 1'b0;
      lock    <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      id_mode <= id_d;
      lock    <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr <= '0;
      pend_data <= '0;
    end else if (pend_we) begin
      pend_addr <= cmd_addr[MEM_AW-1:0];
      pend_data <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_mask <= '0;
    end else if (mask_we) begin
      erase_mask <= mask_d;
    end
  end

  assign busy      = (st_q == ST_PBUSY) || (st_q == ST_EBUSY);
  assign prog_busy = (st_q == ST_PBUSY);

endmodule

// File: rtl/nor_cmd_array.sv
module nor_cmd_array #(
  parameter int MEM_AW = 8,
  parameter int SECT_W = 2
) (
  input  logic                   clk,
  input  logic                   commit_prog,
  input  logic                   commit_erase,
  input  logic [MEM_AW-1:0]      pend_addr,
  input  logic [7:0]             pend_data,
  input  logic [(1<<SECT_W)-1:0] erase_mask,
  input  logic [MEM_AW-1:0]      rd_addr,
  output logic [7:0]             rd_byte
);

  localparam int DEPTH   = 1 << MEM_AW;
  localparam int SECT_SZ = DEPTH >> SECT_W;

  logic [7:0] cell_v [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [7:0] cell_q;
    logic       hit_p;
    logic       hit_e;
    assign hit_p = commit_prog && (pend_addr == MEM_AW'(i));
    assign hit_e = commit_erase && erase_mask[i / SECT_SZ];
    // array cells are not reset: contents survive a block reset
    always_ff @(posedge clk) begin
      if (hit_p)      cell_q <= cell_q & pend_data;
      else if (hit_e) cell_q <= 8'hFF;
    end
    assign cell_v[i] = cell_q;
  end

  assign rd_byte = cell_v[rd_addr];

endmodule

// File: rtl/nor_cmd_rdpath.sv
module nor_cmd_rdpath
  import nor_cmd_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [MEM_AW-1:0] rd_addr,
  input  logic              busy,
  input  logic              prog_busy,
  input  logic [MEM_AW-1:0] pend_addr,
  input  logic              pend_d7,
  input  logic              id_mode,
  input  logic              lock,
  input  logic [7:0]        arr_byte,
  output logic [7:0]        rdata
);

  logic       tgl_q;
  logic [7:0] rd_d;
  logic       poll_bit;

  assign poll_bit = (prog_busy && (rd_addr == pend_addr)) ? ~pend_d7 : 1'b0;

  always_comb begin
    if (busy) begin
      rd_d = {poll_bit, ~tgl_q, 6'd0};
    end else if (id_mode) begin
      if (rd_addr == MEM_AW'(0))      rd_d = ID_MFR;
      else if (rd_addr == MEM_AW'(1)) rd_d = ID_DEV;
      else if (rd_addr == MEM_AW'(2)) rd_d = {7'd0, lock};
      else                            rd_d = 8'h00;
    end else begin
      rd_d = arr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q <= 1'b0;
    end else if (!busy) begin
      tgl_q <= 1'b0;
    end else if (rd_en) begin
      tgl_q <= ~tgl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= 8'h00;
    end else if (rd_en) begin
      rdata <= rd_d;
    end
  end

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
  parameter int ADDR_W    = 18,
  parameter int MEM_AW    = 8,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              busy
);

  localparam int NSECT = 1 << SECT_W;

  logic              rst_q;
  logic              prog_busy, id_mode, lock;
  logic              commit_prog, commit_erase;
  logic [MEM_AW-1:0] pend_addr;
  logic [7:0]        pend_data;
  logic [NSECT-1:0]  erase_mask;
  logic [7:0]        arr_byte;
  logic              unused_hi;

  assign unused_hi = ^addr[ADDR_W-1:15];

  nor_cmd_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  nor_cmd_fsm #(
    .MEM_AW    (MEM_AW),
    .SECT_W    (SECT_W),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_q),
    .wr_en        (wr_en),
    .cmd_addr     (addr[14:0]),
    .wdata        (wdata),
    .busy         (busy),
    .prog_busy    (prog_busy),
    .id_mode      (id_mode),
    .lock         (lock),
    .pend_addr    (pend_addr),
    .pend_data    (pend_data),
    .commit_prog  (commit_prog),
    .commit_erase (commit_erase),
    .erase_mask   (erase_mask)
  );

  nor_cmd_array #(
    .MEM_AW (MEM_AW),
    .SECT_W (SECT_W)
  ) u_arr (
    .clk          (clk),
    .commit_prog  (commit_prog),
    .commit_erase (commit_erase),
    .pend_addr    (pend_addr),
    .pend_data    (pend_data),
    .erase_mask   (erase_mask),
    .rd_addr      (addr[MEM_AW-1:0]),
    .rd_byte      (arr_byte)
  );

  nor_cmd_rdpath #(
    .MEM_AW (MEM_AW)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_q),
    .rd_en     (rd_en),
    .rd_addr   (addr[MEM_AW-1:0]),
    .busy      (busy),
    .prog_busy (prog_busy),
    .pend_addr (pend_addr),
    .pend_d7   (pend_data[7]),
    .id_mode   (id_mode),
    .lock      (lock),
    .arr_byte  (arr_byte),
    .rdata     (rdata)
  );

endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
module nor_cmd_ctrl_chk #(
  parameter int SECT_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic                   busy,
  input logic [6:0]             rdata,
  input logic                   lock,
  input logic                   commit_prog,
  input logic                   commit_erase,
  input logic [SECT_W-1:0]      pend_sect,
  input logic [(1<<SECT_W)-1:0] erase_mask
);

  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en)); // R2

  AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_prog || commit_erase) |=> !busy); // R2

  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> (rdata[5:0] == 6'd0)); // R8

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en && $past(busy && rd_en)) |=> (rdata[6] != $past(rdata[6]))); // R8

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock); // R7

  AST_BOOT_PROG_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && commit_prog) |-> (pend_sect != '0)); // R7

  AST_BOOT_ERASE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && commit_erase) |-> !erase_mask[0]); // R4

  AST_BUSY_IGNORES_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(erase_mask)); // R9

endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk #(
  .SECT_W (SECT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_q),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .busy         (busy),
  .rdata        (rdata[6:0]),
  .lock         (lock),
  .commit_prog  (commit_prog),
  .commit_erase (commit_erase),
  .pend_sect    (pend_addr[MEM_AW-1 -: SECT_W]),
  .erase_mask   (erase_mask)
);

// File: tb/nor_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module nor_cmd_ctrl_tb;

  localparam int PROG_CYC  = 16;
  localparam int ERASE_CYC = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [17:0] addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        busy;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  nor_cmd_ctrl #(
    .ADDR_W (18), .MEM_AW (8), .SECT_W (2),
    .PROG_CYC (PROG_CYC), .ERASE_CYC (ERASE_CYC)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .rdata (rdata), .busy (busy)
  );

  // kinds: write, read-check, wait idle, busy-low check, key pair, erase prefix
  localparam logic [2:0] K_W = 3'd0, K_R = 3'd1, K_WT = 3'd2, K_NB = 3'd3, K_U = 3'd4, K_E = 3'd5;

  typedef struct packed {
    logic [2:0]  kind;
    logic [3:0]  req;
    logic [17:0] a;
    logic [7:0]  d;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 70;
  localparam vec_t TBL [NV] = '{
    // R4 chip erase, unlocked
    '{K_E, 4'd4, 18'h00000, 8'h00, 8'h00},
    '{K_W, 4'd4, 18'h05555, 8'h10, 8'h00},
    '{K_WT,4'd4, 18'h00000, 8'h00, 8'h00},
    '{K_R, 4'd4, 18'h00010, 8'h00, 8'hFF},
    '{K_R, 4'd4, 18'h000C3, 8'h00, 8'hFF},
    '{K_R, 4'd4, 18'h00002, 8'h00, 8'hFF},
    // R1 upper address bits ignored in command matching
    '{K_W, 4'd1, 18'h3D555, 8'hAA, 8'h00},
    '{K_W, 4'd1, 18'h2AAAA, 8'h55, 8'h00},
    '{K_W, 4'd1, 18'h1D555, 8'hA0, 8'h00},
    '{K_W, 4'd1, 18'h00080, 8'h5A, 8'h00},
    '{K_WT,4'd1, 18'h00000, 8'h00, 8'h00},
    '{K_R, 4'd1, 18'h00080, 8'h00, 8'h5A},
    // R3 program ANDs into the old byte
    '{K_U, 4'd3, 18'h00000, 8'h00, 8'h00},
    '{K_W, 4'd3, 18'h05555, 8'hA0, 8'h00},
    '{K_W, 4'd3, 18'h00080, 8'h0F, 8'h00},
    '{K_WT,4'd3, 18'h00000, 8'h00, 8'h00},
    '{K_R, 4'd3, 18'h00080, 8'h00, 8'h0A},
    // R2 boot sector programs while unlocked
    '{K_U, 4'd2, 18'h00000, 8'h00, 8'h00},
    '{K_W, 4'd2, 18'h05555, 8'hA0, 8'h00},
    '{K_W, 4'd2, 18'h00010, 8'h12, 8'h00},
    '{K_WT,4'd2, 18'h00000, 8'h00, 8'h00},
    '{K_R, 4'd2, 18'h00010, 8'h00, 8'h12},
    // R10 broken second key
    '{K_W, 4'd10,18'h05555, 8'hAA, 8'h00},
    '{K_W, 4'd10,18'h01234, 8'h55, 8'h00},
    '{K_W, 4'd10,18'h05555, 8'hA0, 8'h00},
    '{K_W, 4'd10,18'h00080, 8'h00, 8'h00},
    '{K_NB,4'd10,18'h00000, 8'h00, 8'h00},
    '{K_R, 4'd10,18'h00080, 8'h00, 8'h0A},
    // R6 identification mode and single-write exit
    '{K_U, 4'd6, 18'h00000, 8'h00, 8'h00},
    '{K_W, 4'd6, 18'h05555, 8'h90, 8'h00},
    '{K_R, 4'd6, 18'h00000, 8'h00, 8'h1F},
    '{K_R, 4'd6, 18'h00001, 8'h00, 8'h07},
    '{K_R, 4'd6, 18'h00002, 8'h00, 8'h00},
    '{K_W, 4'd6, 18'h00033, 8'hF0, 8'h00},
    '{K_R, 4'd6, 18'h00010, 8'h00, 8'h12},
    '{K_R, 4'd6, 18'h00000, 8'h00, 8'hFF},
    // R5 sector 2 erase
    '{K_E, 4'd5, 18'h00000, 8'h00, 8'h00},
    '{K_W, 4'd5, 18'h00080, 8'h30, 8'h00},
    '{K_WT,4'd5, 18'h00000, 8'h00, 8'h00},
    '{K_R, 4'd5, 18'h00080, 8'h00, 8'hFF},
    '{K_R, 4'd5, 18'h00010, 8'h00, 8'h12},
    // R5 sector erase aimed at boot sector
    '{K_E, 4'd5, 18'h00000, 8'h00, 8'h00},
    '{K_W, 4'd5, 18'h00005, 8'h30, 8'h00},
    '{K_NB,4'd5, 18'h00000, 8'h00, 8'h00},
    '{K_R, 4'd5, 18'h00010, 8'h00, 8'h12},
    // R7 set lock, see it in identification mode
    '{K_E, 4'd7, 18'h00000, 8'h00, 8'h00},
    '{K_W, 4'd7, 18'h05555, 8'h40, 8'h00},
    '{K_NB,4'd7, 18'h00000, 8'h00, 8'h00},
    '{K_U, 4'd7, 18'h00000, 8'h00, 8'h00},
    '{K_W, 4'd7, 18'h05555, 8'h90, 8'h00},
    '{K_R, 4'd7, 18'h00002, 8'h00, 8'h01},
    // R6 full-sequence exit
    '{K_U, 4'd6, 18'h00000, 8'h00, 8'h00},
    '{K_W, 4'd6, 18'h05555, 8'hF0, 8'h00},
    '{K_R, 4'd6, 18'h00002, 8'h00, 8'hFF},
    // R7 locked boot program has no effect
    '{K_U, 4'd7, 18'h00000, 8'h00, 8'h00},
    '{K_W, 4'd7, 18'h05555, 8'hA0, 8'h00},
    '{K_W, 4'd7, 18'h00010, 8'h00, 8'h00},
    '{K_NB,4'd7, 18'h00000, 8'h00, 8'h00},
    '{K_R, 4'd7, 18'h00010, 8'h00, 8'h12},
    // R2 program in sector 3
    '{K_U, 4'd2, 18'h00000, 8'h00, 8'h00},
    '{K_W, 4'd2, 18'h05555, 8'hA0, 8'h00},
    '{K_W, 4'd2, 18'h000C3, 8'h33, 8'h00},
    '{K_WT,4'd2, 18'h00000, 8'h00, 8'h00},
    '{K_R, 4'd2, 18'h000C3, 8'h00, 8'h33},
    // R4 chip erase with lock keeps boot sector
    '{K_E, 4'd4, 18'h00000, 8'h00, 8'h00},
    '{K_W, 4'd4, 18'h05555, 8'h10, 8'h00},
    '{K_WT,4'd4, 18'h00000, 8'h00, 8'h00},
    '{K_R, 4'd4, 18'h000C3, 8'h00, 8'hFF},
    '{K_R, 4'd4, 18'h00010, 8'h00, 8'h12},
    '{K_R, 4'd4, 18'h00080, 8'h00, 8'hFF}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [17:0] a, output logic [7:0] q);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    q = rdata;
  endtask

  task automatic keys();
    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h55);
  endtask

  task automatic erase_prefix();
    keys();
    wr(18'h05555, 8'h80);
    keys();
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int         n;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 busy in reset", 16'(busy), 16'h0);
    check("R11 rdata in reset", 16'(rdata), 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      case (v.kind)
        K_W:  wr(v.a, v.d);
        K_U:  keys();
        K_E:  erase_prefix();
        K_R: begin
          rd(v.a, q);
          check($sformatf("R%0d vec %0d", v.req, i), 16'(q), 16'(v.exp));
        end
        K_WT: begin
          count_busy(n);
          if (n >= 2000) check($sformatf("R%0d vec %0d stuck busy", v.req, i), 16'(busy), 16'h0);
        end
        K_NB: check($sformatf("R%0d vec %0d busy", v.req, i), 16'(busy), 16'h0);
        default: ;
      endcase
    end

    // R2 program duration
    keys(); wr(18'h05555, 8'hA0); wr(18'h000C1, 8'hFE);
    count_busy(n);
    check("R2 program cycles", 16'(n), 16'(PROG_CYC));

    // R8 status reads while programming 0x7F into 0xC0
    keys(); wr(18'h05555, 8'hA0); wr(18'h000C0, 8'h7F);
    rd(18'h000C0, q); check("R8 first poll", 16'(q), 16'h00C0);
    rd(18'h000C0, q); check("R8 second poll", 16'(q), 16'h0080);
    rd(18'h00081, q); check("R8 other address", 16'(q), 16'h0040);
    count_busy(n);
    rd(18'h000C0, q); check("R8 true data after", 16'(q), 16'h007F);

    // R4 chip erase duration
    erase_prefix(); wr(18'h05555, 8'h10);
    count_busy(n);
    check("R4 erase cycles", 16'(n), 16'(ERASE_CYC));

    // R9 full program sequence sent during a chip erase
    erase_prefix(); wr(18'h05555, 8'h10);
    keys(); wr(18'h05555, 8'hA0); wr(18'h000C0, 8'h00);
    check("R9 still busy", 16'(busy), 16'h1);
    count_busy(n);
    rd(18'h000C0, q); check("R9 program ignored", 16'(q), 16'h00FF);
    wr(18'h000C0, 8'h00);
    check("R9 decoder not armed", 16'(busy), 16'h0);
    rd(18'h000C0, q); check("R9 array untouched", 16'(q), 16'h00FF);

    // R11 reset during a program
    keys(); wr(18'h05555, 8'hA0); wr(18'h000C0, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 busy dropped", 16'(busy), 16'h0);
    check("R11 rdata cleared", 16'(rdata), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(18'h000C0, q); check("R11 program aborted", 16'(q), 16'h00FF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule